// File: doc/BRIEF.md
# UART Control and Event Register Block

This block is the software-facing control layer of a serial port. A processor reaches it over a simple 32-bit register bus with byte addresses and word-aligned offsets. It commands the transmit and receive paths through write-one task registers, collects sticky event flags from the serial datapath, and raises one interrupt line. The bit-level shifter, the baud generator and any receive buffering sit outside this block.

The block stays dormant until software writes a specific key value (4) to its enable register. While dormant it answers every read with zero and drops every write except one to the enable register. Transmit bytes go to an external shifter through a valid/done handshake, and only one byte can be in flight at a time. The receiver reports received data and line breaks through single-cycle pulse inputs. Event bit positions inside the interrupt-enable register are: bit 0 receive-ready, bit 1 transmit-ready, bit 2 error, bit 3 receive-timeout.

Top module: `uart_ctl_regs`

## Requirements
- R1: `irq` is high exactly when at least one event flag is set together with its enable bit (bit 0 receive-ready, bit 1 transmit-ready, bit 2 error, bit 3 receive-timeout). It follows a change in flags or enables by the cycle after the change.
- R2: A write of 4 to the enable register (0xA4) turns the block on, and a write of 0 turns it off. Any other value leaves the state unchanged. While the block is on, a read at 0xA4 returns 4.
- R3: While the block is off, every read returns 0 and every write other than one to 0xA4 has no effect.
- R4: Turning the block off clears both the transmit-running and receive-running states and sets the receive-timeout flag, which reads 1 at 0x4C once the block is on again.
- R5: The interrupt-enable register is reached at 0x80 (replace), 0x84 (OR in the written bits) and 0x88 (clear the written bits). A read at any of these three offsets returns the current value.
- R6: A write to the transmit-data register (0xC4) is accepted only while transmit is running and no byte is pending. An accepted byte drives `tx_valid` high with `tx_byte` held steady until `tx_done`. Then `tx_valid` falls and the transmit-ready flag (0x44) is set. Writes made while a byte is pending are dropped.
- R7: Task registers act only on the value 1. Start-RX at 0x00 and start-TX at 0x08 set their running states. Stop-TX at 0x0C clears only transmit-running. Stop-RX at 0x04 clears receive-running and sets receive-timeout. Suspend at 0x10 clears both running states and sets receive-timeout.
- R8: The error-source register (0xA0) is write-one-to-clear. A `brk_evt` pulse sets its two low bits (value 3) and sets the error flag (0x48).
- R9: The transmit-ready, error and receive-timeout flags (0x44, 0x48, 0x4C) take a direct write, where non-zero sets the flag and zero clears it. The receive-ready flag (0x40) is set by an `rx_evt` pulse, and a write clears it only when the value is 0. A hardware set wins over a software write in the same cycle.
- R10: After reset the pin-select words (0xB0, 0xB4, 0xB8, 0xBC) hold all ones and the baud word (0xC8) holds 0x04000000. All other registers, flags and running states are zero, and `irq`, `tx_valid`, `tx_run` and `rx_run` are low.
- R11: Offsets with no defined function behave as plain 32-bit read/write storage.
- R12: `bus_rdata` is registered. It shows the result of a read issued in the previous cycle and holds that value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (8) | Byte address of the access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW (32) | Write data |
| bus_ren | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DW (32) | Read data, valid the cycle after `bus_ren` |
| tx_valid | output | 1 | A transmit byte is pending for the shifter |
| tx_byte | output | BW (8) | Byte handed to the shifter |
| tx_done | input | 1 | Pulse from the shifter: the pending byte has gone |
| rx_evt | input | 1 | Pulse from the receiver: a byte has arrived |
| brk_evt | input | 1 | Pulse from the receiver: line break seen |
| tx_run | output | 1 | Transmit path started |
| rx_run | output | 1 | Receive path started |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the pending-byte window: a second transmit write made before `tx_done` must leave `tx_byte` unchanged, and a design that overwrote it would corrupt the byte in flight. It checks that a disable both clears the running states and leaves a receive-timeout flag behind; a design that treated disable as a plain state bit would lose that event. The write-only-zero rule on receive-ready and the write-one-clear rule on the error source are exercised with non-zero and partial masks. A design that stored the raw value would leave the flag stuck, or wipe both source bits at once. Writes made while the block is off are tried against storage and the interrupt enable, to catch a gate that covers reads but not writes.

// File: rtl/uctl_pkg.sv
`timescale 1ns/1ps
package uctl_pkg;
  // event bit positions, shared by flags and interrupt enables
  localparam int NEV       = 4;
  localparam int EV_RXRDY  = 0;
  localparam int EV_TXRDY  = 1;
  localparam int EV_ERR    = 2;
  localparam int EV_RXTO   = 3;

  // byte offsets
  localparam int OFF_STARTRX = 'h00;
  localparam int OFF_STOPRX  = 'h04;
  localparam int OFF_STARTTX = 'h08;
  localparam int OFF_STOPTX  = 'h0C;
  localparam int OFF_SUSPEND = 'h10;
  localparam int OFF_EVBASE  = 'h40;  // event i lives at OFF_EVBASE + 4*i
  localparam int OFF_IEN     = 'h80;
  localparam int OFF_IENSET  = 'h84;
  localparam int OFF_IENCLR  = 'h88;
  localparam int OFF_ERRSRC  = 'hA0;
  localparam int OFF_ENABLE  = 'hA4;
  localparam int OFF_PINBASE = 'hB0;
  localparam int NPIN        = 4;
  localparam int OFF_TXDATA  = 'hC4;
  localparam int OFF_BAUD    = 'hC8;

  localparam int ENABLE_KEY  = 4;
  localparam logic [31:0] BAUD_RESET = 32'h0400_0000;

  typedef struct packed {
    logic start_tx;
    logic stop_tx;
    logic start_rx;
    logic stop_rx;
    logic suspend;
    logic shut;
  } cmd_t;
endpackage

// File: rtl/uctl_tasks.sv
`timescale 1ns/1ps
module uctl_tasks
  import uctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cmd_t cmd,
  output logic tx_run,
  output logic rx_run
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_run <= 1'b0;
      rx_run <= 1'b0;
    end else begin
      if (cmd.stop_tx || cmd.suspend || cmd.shut) tx_run <= 1'b0;
      else if (cmd.start_tx)                      tx_run <= 1'b1;
      if (cmd.stop_rx || cmd.suspend || cmd.shut) rx_run <= 1'b0;
      else if (cmd.start_rx)                      rx_run <= 1'b1;
    end
  end

  assert_stoptx_only_tx_R7: assert property (@(posedge clk) disable iff (rst)
    cmd.stop_tx |=> (!tx_run && rx_run == $past(rx_run)));
  assert_shut_stops_both_R4: assert property (@(posedge clk) disable iff (rst)
    cmd.shut |=> (!tx_run && !rx_run));
endmodule

// File: rtl/uctl_events.sv
`timescale 1ns/1ps
module uctl_events
  import uctl_pkg::*;
#(
  parameter int DW   = 32,
  parameter int ES_W = 4
)(
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   wdata,
  input  logic [NEV-1:0]  we_evt,
  input  logic            we_ien,
  input  logic            we_ienset,
  input  logic            we_ienclr,
  input  logic            we_errsrc,
  input  cmd_t            cmd,
  input  logic            set_rxrdy,
  input  logic            set_txrdy,
  input  logic            set_brk,
  output logic [NEV-1:0]  flags,
  output logic [NEV-1:0]  ien,
  output logic [ES_W-1:0] errsrc,
  output logic            irq
);
  logic [NEV-1:0]  flags_nx;
  logic [ES_W-1:0] es_nx;
  logic            wnz;

  assign wnz = (wdata != '0);

  always_comb begin
    flags_nx = flags;
    for (int i = 0; i < NEV; i++) begin
      if (we_evt[i]) begin
        if (i == EV_RXRDY) flags_nx[i] = wnz ? flags[i] : 1'b0;
        else               flags_nx[i] = wnz;
      end
    end
    if (set_rxrdy) flags_nx[EV_RXRDY] = 1'b1;
    if (set_txrdy) flags_nx[EV_TXRDY] = 1'b1;
    if (set_brk)   flags_nx[EV_ERR]   = 1'b1;
    if (cmd.stop_rx || cmd.suspend || cmd.shut) flags_nx[EV_RXTO] = 1'b1;

    es_nx = errsrc;
    if (we_errsrc) es_nx = errsrc & ~wdata[ES_W-1:0];
    if (set_brk)   es_nx[1:0] = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      ien    <= '0;
      errsrc <= '0;
    end else begin
      flags  <= flags_nx;
      errsrc <= es_nx;
      if (we_ien)         ien <= wdata[NEV-1:0];
      else if (we_ienset) ien <= ien | wdata[NEV-1:0];
      else if (we_ienclr) ien <= ien & ~wdata[NEV-1:0];
    end
  end

  assign irq = |(flags & ien);

  assert_ienset_or_R5: assert property (@(posedge clk) disable iff (rst)
    we_ienset |=> ((ien & $past(wdata[NEV-1:0])) == $past(wdata[NEV-1:0])));
  assert_brk_sets_R8: assert property (@(posedge clk) disable iff (rst)
    set_brk |=> (errsrc[1:0] == 2'b11 && flags[EV_ERR]));
  assert_rxto_on_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd.stop_rx || cmd.suspend || cmd.shut) |=> flags[EV_RXTO]);
endmodule

// File: rtl/uctl_store.sv
`timescale 1ns/1ps
module uctl_store
  import uctl_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int NW = 2 ** (AW - 2)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-3:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] words [NW];

  function automatic logic [DW-1:0] init_val(input int w);
    if (w >= OFF_PINBASE / 4 && w < OFF_PINBASE / 4 + NPIN) return '1;
    if (w == OFF_BAUD / 4) return DW'(BAUD_RESET);
    return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) words[i] <= init_val(i);
    end else if (we) begin
      words[idx] <= wdata;
    end
  end

  assign rdata = words[idx];
endmodule

// File: rtl/uart_ctl_regs.sv
`timescale 1ns/1ps
module uart_ctl_regs
  import uctl_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int BW   = 8,
  parameter int ES_W = 4
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wen,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_ren,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  output logic [BW-1:0] tx_byte,
  input  logic          tx_done,
  input  logic          rx_evt,
  input  logic          brk_evt,
  output logic          tx_run,
  output logic          rx_run,
  output logic          irq
);
  int              a;
  logic            en;
  logic            wr_ok;
  logic            is_one;
  logic            special;
  logic            tx_accept;
  logic            tx_fin;
  cmd_t            cmd;
  logic [NEV-1:0]  we_evt;
  logic [NEV-1:0]  flags;
  logic [NEV-1:0]  ien;
  logic [ES_W-1:0] errsrc;
  logic [DW-1:0]   st_rd;
  logic [DW-1:0]   rd_mux;

  assign a      = int'(bus_addr);
  assign wr_ok  = bus_wen && (en || a == OFF_ENABLE);
  assign is_one = (bus_wdata == DW'(1));

  // task strobes
  always_comb begin
    cmd          = '0;
    cmd.start_tx = wr_ok && a == OFF_STARTTX && is_one;
    cmd.stop_tx  = wr_ok && a == OFF_STOPTX  && is_one;
    cmd.start_rx = wr_ok && a == OFF_STARTRX && is_one;
    cmd.stop_rx  = wr_ok && a == OFF_STOPRX  && is_one;
    cmd.suspend  = wr_ok && a == OFF_SUSPEND && is_one;
    cmd.shut     = wr_ok && a == OFF_ENABLE  && bus_wdata == '0;
  end

  for (genvar g = 0; g < NEV; g++) begin : g_evdec
    assign we_evt[g] = wr_ok && a == OFF_EVBASE + 4 * g;
  end

  assign special = (a >= OFF_STARTRX && a <= OFF_SUSPEND) ||
                   (a >= OFF_EVBASE && a < OFF_EVBASE + 4 * NEV) ||
                   a == OFF_IEN || a == OFF_IENSET || a == OFF_IENCLR ||
                   a == OFF_ERRSRC || a == OFF_ENABLE || a == OFF_TXDATA;

  // enable key register
  always_ff @(posedge clk) begin
    if (rst) en <= 1'b0;
    else if (bus_wen && a == OFF_ENABLE) begin
      if (bus_wdata == DW'(ENABLE_KEY)) en <= 1'b1;
      else if (bus_wdata == '0)         en <= 1'b0;
    end
  end

  // transmit handoff
  assign tx_accept = wr_ok && a == OFF_TXDATA && tx_run && !tx_valid;
  assign tx_fin    = tx_valid && tx_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else if (tx_accept) begin
      tx_valid <= 1'b1;
      tx_byte  <= bus_wdata[BW-1:0];
    end else if (tx_fin) begin
      tx_valid <= 1'b0;
    end
  end

  uctl_tasks u_tasks (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .tx_run (tx_run),
    .rx_run (rx_run)
  );

  uctl_events #(.DW(DW), .ES_W(ES_W)) u_events (
    .clk       (clk),
    .rst       (rst),
    .wdata     (bus_wdata),
    .we_evt    (we_evt),
    .we_ien    (wr_ok && a == OFF_IEN),
    .we_ienset (wr_ok && a == OFF_IENSET),
    .we_ienclr (wr_ok && a == OFF_IENCLR),
    .we_errsrc (wr_ok && a == OFF_ERRSRC),
    .cmd       (cmd),
    .set_rxrdy (rx_evt),
    .set_txrdy (tx_fin),
    .set_brk   (brk_evt),
    .flags     (flags),
    .ien       (ien),
    .errsrc    (errsrc),
    .irq       (irq)
  );

  uctl_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_ok && !special),
    .idx   (bus_addr[AW-1:2]),
    .wdata (bus_wdata),
    .rdata (st_rd)
  );

  // read path
  always_comb begin
    rd_mux = st_rd;
    if (a == OFF_IEN || a == OFF_IENSET || a == OFF_IENCLR) rd_mux = DW'(ien);
    else if (a == OFF_ERRSRC) rd_mux = DW'(errsrc);
    else if (a == OFF_ENABLE) rd_mux = en ? DW'(ENABLE_KEY) : '0;
    else if (a == OFF_TXDATA) rd_mux = DW'(tx_byte);
    else begin
      for (int i = 0; i < NEV; i++)
        if (a == OFF_EVBASE + 4 * i) rd_mux = DW'(flags[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= en ? rd_mux : '0;
  end

  assert_rd_off_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && !en) |=> (bus_rdata == '0));
  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_byte)));
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_ren |=> $stable(bus_rdata));
endmodule

// File: tb/uart_ctl_regs_tb.sv
`timescale 1ns/1ps
module uart_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ren = 1'b0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_done = 1'b0;
  logic        rx_evt = 1'b0;
  logic        brk_evt = 1'b0;
  logic        tx_run, rx_run, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_ctl_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_done(tx_done),
    .rx_evt(rx_evt), .brk_evt(brk_evt), .tx_run(tx_run), .rx_run(rx_run),
    .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read and compare, 2 compare irq
    logic [7:0]  a;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 8'hC8, 32'h0},          // R3 read while off
    '{2'd0, 8'h80, 32'hF},          // R3 write while off, dropped
    '{2'd0, 8'hA4, 32'h4},          // R2 key
    '{2'd1, 8'h80, 32'h0},          // R3 earlier write had no effect
    '{2'd1, 8'hA4, 32'h4},          // R2 reads key
    '{2'd1, 8'hC8, 32'h0400_0000},  // R10 baud reset
    '{2'd1, 8'hB0, 32'hFFFF_FFFF},  // R10 pin word
    '{2'd1, 8'hBC, 32'hFFFF_FFFF},  // R10 pin word
    '{2'd1, 8'h40, 32'h0},          // R10 flag clear
    '{2'd0, 8'h80, 32'h5},          // R5 replace
    '{2'd1, 8'h84, 32'h5},          // R5 read via set alias
    '{2'd0, 8'h84, 32'h2},          // R5 OR in
    '{2'd1, 8'h88, 32'h7},          // R5 read via clear alias
    '{2'd0, 8'h88, 32'h4},          // R5 clear bits
    '{2'd1, 8'h80, 32'h3},          // R5
    '{2'd0, 8'h44, 32'h1},          // R9 direct set tx-ready
    '{2'd2, 8'h00, 32'h1},          // R1 flag and enable
    '{2'd0, 8'h88, 32'h2},          // R1 remove enable
    '{2'd2, 8'h00, 32'h0},          // R1
    '{2'd1, 8'h44, 32'h1},          // R9 flag kept
    '{2'd0, 8'h44, 32'h0},          // R9 clear by zero
    '{2'd1, 8'h44, 32'h0},          // R9
    '{2'd0, 8'h20, 32'hDEAD_BEEF},  // R11 storage
    '{2'd1, 8'h20, 32'hDEAD_BEEF},  // R11
    '{2'd1, 8'h24, 32'h0},          // R11 neighbour untouched
    '{2'd0, 8'hA4, 32'h5},          // R2 bad key ignored
    '{2'd1, 8'hA4, 32'h4}           // R2 still on
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse_tx_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_evt = 1'b1;
    @(negedge clk); rx_evt = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk); brk_evt = 1'b1;
    @(negedge clk); brk_evt = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 irq", {31'd0, irq}, 32'd0);
    chk("R10 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R10 run states", {30'd0, tx_run, rx_run}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].a, VEC[i].d);
        2'd1: rd(VEC[i].a, VEC[i].d, $sformatf("vector %0d read", i));
        default: chk($sformatf("vector %0d irq", i), {31'd0, irq}, VEC[i].d);
      endcase
    end

    // transmit handshake
    wr(8'hC4, 32'h5A);
    chk("R6 write before start dropped", {31'd0, tx_valid}, 32'd0);
    wr(8'h08, 32'h1);
    chk("R7 start tx", {31'd0, tx_run}, 32'd1);
    wr(8'hC4, 32'h5A);
    chk("R6 byte pending", {23'd0, tx_valid, tx_byte}, {23'd0, 1'b1, 8'h5A});
    wr(8'hC4, 32'h33);
    chk("R6 second write dropped", {24'd0, tx_byte}, 32'h5A);
    pulse_tx_done();
    chk("R6 pending cleared", {31'd0, tx_valid}, 32'd0);
    rd(8'h44, 32'h1, "R6 tx-ready set");
    wr(8'h44, 32'h0);

    // tasks
    wr(8'h0C, 32'h2);
    chk("R7 stop value 2 ignored", {31'd0, tx_run}, 32'd1);
    wr(8'h00, 32'h1);
    chk("R7 start rx", {31'd0, rx_run}, 32'd1);
    wr(8'h0C, 32'h1);
    chk("R7 stop tx only", {30'd0, tx_run, rx_run}, 32'd1);
    wr(8'h04, 32'h1);
    chk("R7 stop rx", {31'd0, rx_run}, 32'd0);
    rd(8'h4C, 32'h1, "R7 stop rx sets timeout");
    wr(8'h4C, 32'h0);
    wr(8'h00, 32'h1);
    wr(8'h08, 32'h1);
    wr(8'h10, 32'h1);
    chk("R7 suspend clears both", {30'd0, tx_run, rx_run}, 32'd0);
    rd(8'h4C, 32'h1, "R7 suspend sets timeout");
    wr(8'h4C, 32'h0);

    // break and error source
    pulse_brk();
    rd(8'hA0, 32'h3, "R8 break source bits");
    rd(8'h48, 32'h1, "R8 error flag");
    wr(8'hA0, 32'h1);
    rd(8'hA0, 32'h2, "R8 write-one-clear");
    wr(8'h48, 32'h0);

    // receive-ready rules
    wr(8'h80, 32'h1);
    pulse_rx();
    chk("R1 irq from rx-ready", {31'd0, irq}, 32'd1);
    rd(8'h40, 32'h1, "R9 rx-ready set");
    wr(8'h40, 32'h1);
    rd(8'h40, 32'h1, "R9 nonzero write kept rx-ready");
    wr(8'h40, 32'h0);
    rd(8'h40, 32'h0, "R9 zero write cleared rx-ready");
    chk("R1 irq dropped", {31'd0, irq}, 32'd0);

    // disable side effects
    wr(8'h00, 32'h1);
    wr(8'h08, 32'h1);
    wr(8'hA4, 32'h0);
    chk("R4 disable stops both", {30'd0, tx_run, rx_run}, 32'd0);
    rd(8'h80, 32'h0, "R3 read while off");
    wr(8'h20, 32'h1234);
    wr(8'hA4, 32'h4);
    rd(8'h4C, 32'h1, "R4 disable sets timeout");
    rd(8'h20, 32'hDEAD_BEEF, "R3 write while off dropped");
    repeat (2) @(negedge clk);
    chk("R12 read data held", bus_rdata, 32'hDEAD_BEEF);
    rd(8'h80, 32'h1, "R3 enable kept across off");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule